// File: doc/BRIEF.md
# Converter-Clocked Serial Result Reader

This host-side block reads a 24-bit conversion word from a delta-sigma converter that drives the serial clock itself. On a request the block pulls the active-low chip select low. It leaves the clock line to the converter, so the converter selects its internal-clock mode. After a short settling window it samples the data line, which at that point carries the end-of-conversion flag. In read mode the block then waits for clock edges from the converter. It samples one data bit on each rising edge, and after the 24th bit it raises chip select and presents the word with a one-cycle strobe.

A poll mode lets the host check whether a result is waiting without starting a read. The block samples the flag, publishes it, and raises chip select before the converter can produce its first clock edge, so the converter stays in its low-power state. The clock and data inputs are asynchronous to the system clock. Each passes through a two-stage synchroniser, and clock edges are found in the system domain. A watchdog counter ends a read when the converter stops clocking. A programmable minimum high time separates consecutive transactions.

Top module: `rdr_host`

## Requirements
- R1: While reset is asserted and after it is released, cs_no is 1, valid_o, timeout_o and poll_done_o are 0, ready_o is 0, busy_o is 0 and result_o is all zeros.
- R2: A request seen while idle drives cs_no low on the next clock edge and latches poll_only_i for the whole transaction. The block has no output on the clock line.
- R3: In poll mode, SETTLE_CYC cycles after cs_no falls, poll_done_o pulses for one cycle. In the same cycle cs_no returns to 1 and ready_o takes the inverse of the synchronised data line (data 0 means a result is ready, so ready_o = 1). ready_o holds this value until the next poll.
- R4: In read mode, each rising edge of the synchronised clock shifts one data bit in. The first bit lands in bit 23, which is the end-of-conversion flag, and the later bits follow most significant first down to bit 0.
- R5: On the 24th rising edge the full word appears on result_o. In the same cycle valid_o pulses for exactly one cycle and cs_no returns to 1.
- R6: result_o changes only when a full frame completes. An aborted read or a poll leaves it unchanged.
- R7: In read mode, if no rising clock edge arrives for TIMEOUT_CYC consecutive cycles, timeout_o pulses for one cycle and cs_no returns to 1. valid_o and timeout_o are never high together.
- R8: Between two transactions cs_no stays high for at least GAP_CYC+1 cycles. When a request is held high continuously, the next transaction starts after exactly GAP_CYC+1 high cycles.
- R9: A request during an active transaction or during the minimum high time has no effect on the transaction in progress. Falling clock edges never capture data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a transaction when idle |
| poll_only_i | input | 1 | 1: poll the ready flag only, 0: read a full frame |
| sck_i | input | 1 | Serial clock driven by the converter (asynchronous) |
| sdo_i | input | 1 | Serial data from the converter (asynchronous) |
| cs_no | output | 1 | Active-low chip select to the converter |
| result_o | output | FRAME_BITS | Last completed frame |
| valid_o | output | 1 | One-cycle strobe when result_o updates |
| ready_o | output | 1 | Ready flag from the last poll |
| poll_done_o | output | 1 | One-cycle strobe when a poll completes |
| timeout_o | output | 1 | One-cycle strobe when a read is aborted for lack of clock edges |
| busy_o | output | 1 | A transaction or the minimum high time is in progress |

## Verification
The bench checks the poll window with the data line held both low and high. A design that samples too early or inverts the flag would report the wrong ready state. A design that holds chip select low too long would let the converter wake up. Full frames are read with alternating and mixed bit patterns to catch a reversed bit order or a dropped first bit. A read that stalls mid-frame has to abort with the previous result intact; a design that updates the result register bit by bit would show a corrupted word. A request held high across transactions checks the exact chip-select high time, which shows both a gap that is too short and a request that restarts a transaction already running.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rdr_state_e;
endpackage

// File: rtl/rdr_sync.sv
module rdr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= din_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];

  assign dout_o = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rdr_shift.sv
module rdr_shift #(
  parameter int BITS = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            bit_i,
  output logic [BITS-1:0] word_o,
  output logic            last_o
);
  localparam int CW = $clog2(BITS + 1);

  logic [BITS-1:0] sh_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sh_q  <= {sh_q[BITS-2:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o = sh_q;
  assign last_o = (cnt_q == CW'(BITS - 1));
endmodule

// File: rtl/rdr_host.sv
module rdr_host
  import rdr_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 8,
  parameter int TIMEOUT_CYC = 100000,
  parameter int GAP_CYC     = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  poll_only_i,
  input  logic                  sck_i,
  input  logic                  sdo_i,
  output logic                  cs_no,
  output logic [FRAME_BITS-1:0] result_o,
  output logic                  valid_o,
  output logic                  ready_o,
  output logic                  poll_done_o,
  output logic                  timeout_o,
  output logic                  busy_o
);
  localparam int MAX_A = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int MAX_C = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
  localparam int CNT_W = $clog2(MAX_C + 1);

  rdr_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic mode_q, valid_q, err_q, poll_q, ready_q;
  logic [FRAME_BITS-1:0] result_q;

  logic [1:0] sync_out, sync_rise;
  logic sck_rise, sdo_s;
  logic sh_clr, sh_en, sh_last;
  logic [FRAME_BITS-1:0] sh_word;

  rdr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i ({sdo_i, sck_i}),
    .dout_o(sync_out),
    .rise_o(sync_rise)
  );
  assign sck_rise = sync_rise[0];
  assign sdo_s    = sync_out[1];

  assign sh_clr = (state_q == ST_IDLE) && req_i;
  assign sh_en  = (state_q == ST_SHIFT) && sck_rise;

  rdr_shift #(.BITS(FRAME_BITS)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sh_clr),
    .en_i  (sh_en),
    .bit_i (sdo_s),
    .word_o(sh_word),
    .last_o(sh_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      poll_q   <= 1'b0;
      ready_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      poll_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          mode_q  <= poll_only_i;
          cnt_q   <= '0;
          state_q <= ST_TEST;
        end
        ST_TEST: begin
          if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
            cnt_q <= '0;
            if (mode_q) begin
              // flag low on the line means a result is waiting
              poll_q  <= 1'b1;
              ready_q <= ~sdo_s;
              state_q <= ST_GAP;
            end else begin
              state_q <= ST_SHIFT;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (sck_rise) begin
            cnt_q <= '0;
            if (sh_last) begin
              result_q <= {sh_word[FRAME_BITS-2:0], sdo_s};
              valid_q  <= 1'b1;
              state_q  <= ST_GAP;
            end
          end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
            err_q   <= 1'b1;
            cnt_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no       = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign busy_o      = (state_q != ST_IDLE);
  assign result_o    = result_q;
  assign valid_o     = valid_q;
  assign timeout_o   = err_q;
  assign poll_done_o = poll_q;
  assign ready_o     = ready_q;
endmodule

// File: rtl/rdr_host_chk.sv
module rdr_host_chk #(
  parameter int GAP_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic valid_o,
  input logic timeout_o,
  input logic poll_done_o
);
  localparam int HW = $clog2(GAP_CYC + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       hi_cnt <= HW'(GAP_CYC + 1);
    else if (!cs_no)                   hi_cnt <= '0;
    else if (hi_cnt != HW'(GAP_CYC + 1)) hi_cnt <= hi_cnt + 1'b1;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_CS_UP_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cs_no); // R5
  AST_CS_UP_ON_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_done_o |-> cs_no); // R3
  AST_CS_UP_ON_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> cs_no); // R7
  AST_NO_DUAL_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && timeout_o)); // R7
  AST_MIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= HW'(GAP_CYC + 1))); // R8
endmodule

bind rdr_host rdr_host_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_no      (cs_no),
  .valid_o    (valid_o),
  .timeout_o  (timeout_o),
  .poll_done_o(poll_done_o)
);

// File: tb/rdr_host_tb_top.sv
module rdr_host_tb_top;
  localparam int FB = 24;
  localparam int SETTLE = 4;
  localparam int TMO = 40;
  localparam int GAP = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, poll_only_i = 1'b0, sck_i = 1'b1, sdo_i = 1'b1;
  logic cs_no, valid_o, ready_o, poll_done_o, timeout_o, busy_o;
  logic [FB-1:0] result_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int n_valid = 0, n_err = 0, n_poll = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rdr_host #(.FRAME_BITS(FB), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE),
             .TIMEOUT_CYC(TMO), .GAP_CYC(GAP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .poll_only_i(poll_only_i),
    .sck_i(sck_i), .sdo_i(sdo_i), .cs_no(cs_no), .result_o(result_o),
    .valid_o(valid_o), .ready_o(ready_o), .poll_done_o(poll_done_o),
    .timeout_o(timeout_o), .busy_o(busy_o));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_st, m_cnt, m_bits;
  bit m_mode, m_c1, m_c2, m_cp, m_d1, m_d2;
  logic [FB-1:0] m_sh, e_result;
  bit e_csn, e_valid, e_err, e_poll, e_ready, e_busy;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_bits = 0; m_mode = 0; m_sh = '0;
      m_c1 = 0; m_c2 = 0; m_cp = 0; m_d1 = 0; m_d2 = 0;
      e_result = '0; e_csn = 1; e_valid = 0; e_err = 0; e_poll = 0;
      e_ready = 0; e_busy = 0;
    end else begin
      bit rise, b;
      rise = m_c2 && !m_cp;
      b = m_d2;
      e_valid = 0; e_err = 0; e_poll = 0;
      case (m_st)
        0: if (req_i) begin m_mode = poll_only_i; m_cnt = 0; m_bits = 0; m_sh = '0; m_st = 1; end
        1: if (m_cnt == SETTLE - 1) begin
             m_cnt = 0;
             if (m_mode) begin e_poll = 1; e_ready = !b; m_st = 3; end
             else m_st = 2;
           end else m_cnt++;
        2: if (rise) begin
             m_sh = (m_sh << 1) | FB'(b); m_bits++; m_cnt = 0;
             if (m_bits == FB) begin e_result = m_sh; e_valid = 1; m_st = 3; end
           end else if (m_cnt == TMO - 1) begin e_err = 1; m_cnt = 0; m_st = 3; end
           else m_cnt++;
        default: if (m_cnt == GAP - 1) begin m_cnt = 0; m_st = 0; end else m_cnt++;
      endcase
      e_csn = (m_st == 0) || (m_st == 3);
      e_busy = (m_st != 0);
      m_cp = m_c2; m_c2 = m_c1; m_c1 = sck_i;
      m_d2 = m_d1; m_d1 = sdo_i;
    end
  end

  always @(negedge clk_i) begin
    cyc++;
    if (valid_o) n_valid++;
    if (timeout_o) n_err++;
    if (poll_done_o) n_poll++;
    if (rst_ni && !done) begin
      chk("R2 R8 cs_no", 32'(cs_no), 32'(e_csn));
      chk("R5 valid_o", 32'(valid_o), 32'(e_valid));
      chk("R7 timeout_o", 32'(timeout_o), 32'(e_err));
      chk("R3 poll_done_o", 32'(poll_done_o), 32'(e_poll));
      chk("R3 ready_o", 32'(ready_o), 32'(e_ready));
      chk("R9 busy_o", 32'(busy_o), 32'(e_busy));
      chk("R4 R6 result_o", 32'(result_o), 32'(e_result));
    end
  end

  task automatic report();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(negedge clk_i)
    if (cyc > 20000 && !done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end

  task automatic cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic start(bit poll);
    @(negedge clk_i);
    req_i = 1; poll_only_i = poll;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic send(logic [FB-1:0] w, int nbits);
    for (int i = FB - 1; i >= FB - nbits; i--) begin
      sdo_i = w[i]; sck_i = 0; cycles(3);
      sck_i = 1; cycles(3);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy_o; i++) @(negedge clk_i);
  endtask

  task automatic read_frame(logic [FB-1:0] w);
    int v0;
    v0 = n_valid;
    sdo_i = 1'b0;
    start(1'b0);
    cycles(8);
    send(w, FB);
    cycles(4);
    chk("R5 one valid per frame", 32'(n_valid - v0), 32'd1);
    chk("R4 word", 32'(result_o), 32'(w));
    wait_idle();
  endtask

  initial begin
    int p0, e0, hi;
    logic [FB-1:0] last;
    cycles(3);
    chk("R1 cs_no", 32'(cs_no), 32'd1);
    chk("R1 result_o", 32'(result_o), 32'd0);
    chk("R1 flags", {valid_o, timeout_o, poll_done_o, ready_o, busy_o}, 32'd0);
    rst_ni = 1'b1;
    cycles(3);
    chk("R1 after release", {cs_no, valid_o, timeout_o, poll_done_o, busy_o}, 32'h10);

    // poll, result waiting
    sdo_i = 0; cycles(3); p0 = n_poll;
    start(1'b1);
    chk("R2 cs low", 32'(cs_no), 32'd0);
    cycles(SETTLE + 2);
    chk("R3 poll seen", 32'(n_poll - p0), 32'd1);
    chk("R3 ready", 32'(ready_o), 32'd1);
    chk("R3 cs high", 32'(cs_no), 32'd1);
    chk("R6 result kept", 32'(result_o), 32'd0);
    wait_idle();

    // poll, busy
    sdo_i = 1; cycles(3);
    start(1'b1); cycles(SETTLE + 2);
    chk("R3 not ready", 32'(ready_o), 32'd0);
    wait_idle();

    read_frame(24'h5A3C96);
    read_frame(24'h0F1E2D);
    read_frame(24'h7FFFFE);

    // stalled frame with request pulses during it
    last = result_o; e0 = n_err;
    sdo_i = 0;
    start(1'b0);
    cycles(8);
    send(24'h123456, 6);
    req_i = 1; poll_only_i = 1; cycles(2); req_i = 0;
    cycles(TMO + 10);
    chk("R7 timeout seen", 32'(n_err - e0), 32'd1);
    chk("R6 result unchanged", 32'(result_o), 32'(last));
    chk("R9 no stray poll", 32'(poll_done_o), 32'd0);
    wait_idle();

    // back-to-back requests: high time between selections
    sdo_i = 1; req_i = 1; poll_only_i = 1;
    for (int i = 0; i < 50 && cs_no; i++) @(negedge clk_i);
    for (int i = 0; i < 50 && !cs_no; i++) @(negedge clk_i);
    hi = 0;
    for (int i = 0; i < 50 && cs_no; i++) begin hi++; @(negedge clk_i); end
    chk("R8 gap cycles", 32'(hi), 32'(GAP + 1));
    req_i = 0;
    wait_idle();
    cycles(4);
    report();
  end
endmodule